// File: doc/BRIEF.md
# Word-Granular Instruction Byte Buffer

This block is a 16-byte instruction queue between an instruction fetch path and variable-length decoders. Each clock the fetch side may present two candidate 32-byte aligned windows, one from the instruction cache and one from the branch-target cache. A select bit picks one of them. The fetch side also gives a word offset into the chosen window. The queue copies as many aligned 2-byte words as it has room for, up to 16 bytes in one cycle, starting at that offset. Each byte carries its own predecode tag. The queue publishes the byte address of the next word it needs on `fetchAddr`, so the fetch side knows which window and offset to offer.

On the decode side the queue shows its oldest valid bytes in order, together with a count of how many are valid. The decoders return a consumed-byte count, at byte granularity. Storage is kept as eight aligned word slots. A slot is released only after both of its bytes have been consumed, and released slots are filled again while the queue still holds other bytes. A redirect discards everything and restarts filling from the target. For an odd target, the first word is loaded whole and its first byte is hidden.

Top module: `ibuf_word_queue`

## Requirements
- R1: After reset `headValid` is 0, `consumeErr` is 0 and `fetchAddr` equals `RESET_ADDR` (default 0).
- R2: When `fetchSel` is 0, loaded bytes and tags come from `icWin`/`icTag`. When it is 1, they come from `btWin`/`btTag`. Window byte b occupies bits [8b+7:8b] of the window bus and bits [4b+3:4b] of the tag bus.
- R3: Loaded words are taken contiguously from the selected window, starting at word `wordOff`. No word past the 32-byte window end is loaded in that cycle, and at most 16 bytes are loaded per cycle.
- R4: When `fetchValid` is high, the number of words loaded is the smaller of the free word slots and the words left in the window. `fetchAddr` stays even and advances by two per loaded word on the next clock.
- R5: `headBytes` byte i (bits [8i+7:8i]) and `headTags` entry i are the i-th oldest valid byte and its tag, for every i below `headValid`.
- R6: A `consumeCnt` of n that is not above `headValid` removes the n oldest bytes. `headValid` on the next cycle equals the old count minus n plus twice the words loaded.
- R7: A word slot is freed only when both of its bytes are consumed. A partly consumed word keeps its remaining byte at the head, and refill uses whole words only.
- R8: A `consumeCnt` above `headValid` raises `consumeErr` in the same cycle and removes nothing.
- R9: A redirect wins over consume and fetch data in the same cycle. On the next cycle `headValid` is 0 and `fetchAddr` is the target with bit 0 cleared.
- R10: After an odd redirect target, the first loaded word is stored whole but its leading byte is never shown, and the head byte is the target byte.
- R11: Space is refilled as soon as a word is free. An empty queue with a valid aligned fetch holds 16 valid bytes after one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| redirect | input | 1 | Control-transfer flush and restart |
| redirectAddr | input | ADDRW | Byte address of the redirect target |
| fetchValid | input | 1 | Fetch windows valid this cycle |
| fetchSel | input | 1 | 0 selects instruction-cache window, 1 branch-target window |
| wordOff | input | 4 | Word offset in the window of the first word to load |
| icWin | input | 256 | Instruction-cache window bytes |
| icTag | input | 32*TAGW | Instruction-cache predecode tags |
| btWin | input | 256 | Branch-target window bytes |
| btTag | input | 32*TAGW | Branch-target predecode tags |
| fetchAddr | output | ADDRW | Byte address of the next word to load |
| consumeCnt | input | 5 | Bytes consumed by the decoders this cycle |
| consumeErr | output | 1 | Consume count exceeds valid bytes |
| headValid | output | 5 | Number of valid head bytes (0..16) |
| headBytes | output | 128 | Head bytes, oldest in byte 0 |
| headTags | output | 16*TAGW | Predecode tags of the head bytes |

## Verification
The hardest case is a queue whose head sits on an odd byte while a refill lands in the same cycle as a consume. In that case the released slot count, the hidden leading byte and the refill size all interact. The case also has to happen near the end of a window, where fewer words remain than are free. Directed steps reach it with a redirect to an odd target two words before a window end, followed by partial consumes. A long seeded random run then mixes odd redirects, over-large consume counts and idle fetch cycles. That run compares every head byte against a bench model of addresses and sources.

// File: rtl/ibq_pkg.sv
package ibq_pkg;

  // Strobes the control side hands to the datapath each cycle.
  typedef struct packed {
    logic flush;
    logic load;
    logic consume;
  } ibqStrobe_t;

endpackage

// File: rtl/ibq_ctrl.sv
module ibq_ctrl
  import ibq_pkg::*;
#(
  parameter int QWORDS     = 8,
  parameter int WINWORDS   = 16,
  parameter int ADDRW      = 32,
  parameter logic [ADDRW-1:0] RESET_ADDR = '0,
  localparam int PTRW  = $clog2(QWORDS),
  localparam int CNTW  = $clog2(QWORDS + 1),
  localparam int BCNTW = $clog2(2 * QWORDS + 1),
  localparam int WOFFW = $clog2(WINWORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              redirect,
  input  logic [ADDRW-1:0]  redirectAddr,
  input  logic              fetchValid,
  input  logic [WOFFW-1:0]  wordOff,
  input  logic [BCNTW-1:0]  consumeCnt,
  output ibqStrobe_t        strobe,
  output logic [CNTW-1:0]   loadWords,
  output logic [PTRW-1:0]   tailSlot,
  output logic [PTRW-1:0]   headWord,
  output logic              headOdd,
  output logic [BCNTW-1:0]  headValid,
  output logic              consumeErr,
  output logic [ADDRW-1:0]  fetchAddr
);

  logic [CNTW-1:0]  wordCnt;
  logic [CNTW-1:0]  freeWords;
  logic [WOFFW:0]   availWords;
  logic [BCNTW:0]   headSum;
  logic [CNTW-1:0]  freedWords;
  logic             consumeOk;

  // Valid bytes: whole stored words, minus a hidden or consumed leading byte.
  always_comb begin
    if (wordCnt == '0) headValid = '0;
    else headValid = BCNTW'({wordCnt, 1'b0}) - BCNTW'(headOdd);
  end

  assign consumeErr = (consumeCnt > headValid);
  assign consumeOk  = !redirect && !consumeErr && (consumeCnt != '0);

  // Words freed by this consume: only pairs completed from the head word.
  assign headSum    = {1'b0, consumeCnt} + (BCNTW+1)'(headOdd);
  assign freedWords = CNTW'(headSum[BCNTW:1]);

  // Refill size comes from the registered count, not from this cycle's consume.
  assign freeWords  = CNTW'(QWORDS) - wordCnt;
  assign availWords = (WOFFW+1)'(WINWORDS) - {1'b0, wordOff};

  always_comb begin
    loadWords = '0;
    if (fetchValid && !redirect) begin
      if (int'(availWords) < int'(freeWords)) loadWords = CNTW'(availWords);
      else loadWords = freeWords;
    end
  end

  assign tailSlot = headWord + PTRW'(wordCnt);

  always_comb begin
    strobe.flush   = redirect;
    strobe.load    = (loadWords != '0);
    strobe.consume = consumeOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordCnt   <= '0;
      headWord  <= '0;
      headOdd   <= RESET_ADDR[0];
      fetchAddr <= {RESET_ADDR[ADDRW-1:1], 1'b0};
    end else if (strobe.flush) begin
      wordCnt   <= '0;
      headWord  <= '0;
      headOdd   <= redirectAddr[0];
      fetchAddr <= {redirectAddr[ADDRW-1:1], 1'b0};
    end else begin
      wordCnt   <= wordCnt + loadWords - (strobe.consume ? freedWords : '0);
      fetchAddr <= fetchAddr + ADDRW'({loadWords, 1'b0});
      if (strobe.consume) begin
        headWord <= headWord + PTRW'(freedWords);
        headOdd  <= headSum[0];
      end
    end
  end

endmodule

// File: rtl/ibq_datapath.sv
module ibq_datapath
  import ibq_pkg::*;
#(
  parameter int QWORDS   = 8,
  parameter int WINWORDS = 16,
  parameter int TAGW     = 4,
  localparam int QBYTES   = 2 * QWORDS,
  localparam int WINBYTES = 2 * WINWORDS,
  localparam int PTRW     = $clog2(QWORDS),
  localparam int CNTW     = $clog2(QWORDS + 1),
  localparam int WOFFW    = $clog2(WINWORDS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ibqStrobe_t                 strobe,
  input  logic [CNTW-1:0]            loadWords,
  input  logic [PTRW-1:0]            tailSlot,
  input  logic [PTRW-1:0]            headWord,
  input  logic                       headOdd,
  input  logic [WOFFW-1:0]           wordOff,
  input  logic                       fetchSel,
  input  logic [WINBYTES*8-1:0]      icWin,
  input  logic [WINBYTES*TAGW-1:0]   icTag,
  input  logic [WINBYTES*8-1:0]      btWin,
  input  logic [WINBYTES*TAGW-1:0]   btTag,
  output logic [QBYTES*8-1:0]        headBytes,
  output logic [QBYTES*TAGW-1:0]     headTags
);

  logic [WINBYTES*8-1:0]    selWin;
  logic [WINBYTES*TAGW-1:0] selTag;
  logic [7:0]      exByte [QBYTES];
  logic [TAGW-1:0] exTag  [QBYTES];
  logic [7:0]      qByte  [QBYTES];
  logic [TAGW-1:0] qTag   [QBYTES];

  // Two-way choice between the cache path and the target-cache path.
  assign selWin = fetchSel ? btWin : icWin;
  assign selTag = fetchSel ? btTag : icTag;

  // Aligner: word k of the extract is window word (wordOff + k).
  for (genvar k = 0; k < QWORDS; k++) begin : g_extract
    for (genvar b = 0; b < 2; b++) begin : g_half
      always_comb begin
        int srcByte;
        srcByte = 2 * ((int'(wordOff) + k) % WINWORDS) + b;
        exByte[2*k+b] = selWin[srcByte*8 +: 8];
        exTag[2*k+b]  = selTag[srcByte*TAGW +: TAGW];
      end
    end
  end

  // Word slots: slot j takes extract word (j - tail) when that lies below the load size.
  for (genvar j = 0; j < QWORDS; j++) begin : g_slot
    logic [PTRW-1:0] rel;
    logic            slotWe;
    assign rel    = PTRW'(j) - tailSlot;
    assign slotWe = strobe.load && !strobe.flush && (CNTW'(rel) < loadWords);

    for (genvar b = 0; b < 2; b++) begin : g_half
      always_ff @(posedge clk) begin
        if (!rstN) begin
          qByte[2*j+b] <= '0;
          qTag[2*j+b]  <= '0;
        end else if (slotWe) begin
          qByte[2*j+b] <= exByte[2*int'(rel)+b];
          qTag[2*j+b]  <= exTag[2*int'(rel)+b];
        end
      end
    end
  end

  // Head rotator: output byte i is storage byte (2*headWord + headOdd + i) mod QBYTES.
  for (genvar i = 0; i < QBYTES; i++) begin : g_head
    logic [PTRW:0] pos;
    assign pos = {headWord, 1'b0} + (PTRW+1)'(headOdd) + (PTRW+1)'(i);
    assign headBytes[i*8 +: 8]     = qByte[pos];
    assign headTags[i*TAGW +: TAGW] = qTag[pos];
  end

endmodule

// File: rtl/ibuf_word_queue.sv
module ibuf_word_queue
  import ibq_pkg::*;
#(
  parameter int QWORDS   = 8,
  parameter int WINWORDS = 16,
  parameter int TAGW     = 4,
  parameter int ADDRW    = 32,
  parameter logic [ADDRW-1:0] RESET_ADDR = '0,
  localparam int QBYTES   = 2 * QWORDS,
  localparam int WINBYTES = 2 * WINWORDS,
  localparam int BCNTW    = $clog2(QBYTES + 1),
  localparam int WOFFW    = $clog2(WINWORDS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      redirect,
  input  logic [ADDRW-1:0]          redirectAddr,
  input  logic                      fetchValid,
  input  logic                      fetchSel,
  input  logic [WOFFW-1:0]          wordOff,
  input  logic [WINBYTES*8-1:0]     icWin,
  input  logic [WINBYTES*TAGW-1:0]  icTag,
  input  logic [WINBYTES*8-1:0]     btWin,
  input  logic [WINBYTES*TAGW-1:0]  btTag,
  output logic [ADDRW-1:0]          fetchAddr,
  input  logic [BCNTW-1:0]          consumeCnt,
  output logic                      consumeErr,
  output logic [BCNTW-1:0]          headValid,
  output logic [QBYTES*8-1:0]       headBytes,
  output logic [QBYTES*TAGW-1:0]    headTags
);

  localparam int PTRW = $clog2(QWORDS);
  localparam int CNTW = $clog2(QWORDS + 1);

  ibqStrobe_t      strobe;
  logic [CNTW-1:0] loadWords;
  logic [PTRW-1:0] tailSlot;
  logic [PTRW-1:0] headWord;
  logic            headOdd;

  ibq_ctrl #(
    .QWORDS(QWORDS), .WINWORDS(WINWORDS), .ADDRW(ADDRW), .RESET_ADDR(RESET_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .redirect(redirect), .redirectAddr(redirectAddr),
    .fetchValid(fetchValid), .wordOff(wordOff), .consumeCnt(consumeCnt),
    .strobe(strobe), .loadWords(loadWords), .tailSlot(tailSlot),
    .headWord(headWord), .headOdd(headOdd), .headValid(headValid),
    .consumeErr(consumeErr), .fetchAddr(fetchAddr)
  );

  ibq_datapath #(
    .QWORDS(QWORDS), .WINWORDS(WINWORDS), .TAGW(TAGW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadWords(loadWords),
    .tailSlot(tailSlot), .headWord(headWord), .headOdd(headOdd),
    .wordOff(wordOff), .fetchSel(fetchSel),
    .icWin(icWin), .icTag(icTag), .btWin(btWin), .btTag(btTag),
    .headBytes(headBytes), .headTags(headTags)
  );

endmodule

// File: rtl/ibuf_word_queue_chk.sv
module ibuf_word_queue_chk #(
  parameter int QBYTES = 16,
  parameter int BCNTW  = 5,
  parameter int ADDRW  = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             redirect,
  input logic             fetchValid,
  input logic             consumeErr,
  input logic [BCNTW-1:0] consumeCnt,
  input logic [BCNTW-1:0] headValid,
  input logic [ADDRW-1:0] fetchAddr
);

  AST_REDIRECT_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    redirect |=> headValid == '0); // R9

  AST_FETCH_ADDR_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    fetchAddr[0] == 1'b0); // R4

  AST_IDLE_FETCH_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!redirect && !fetchValid) |=> $stable(fetchAddr)); // R4

  AST_LOAD_AT_MOST_QUEUE: assert property (@(posedge clk) disable iff (!rstN)
    (!redirect && fetchValid) |=> (fetchAddr - $past(fetchAddr)) <= ADDRW'(QBYTES)); // R3

  AST_VALID_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    headValid <= BCNTW'(QBYTES)); // R6

  AST_CONSUME_REMOVES: assert property (@(posedge clk) disable iff (!rstN)
    (!redirect && !fetchValid && !consumeErr)
      |=> headValid == $past(headValid) - $past(consumeCnt)); // R6

  AST_BAD_CONSUME_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (consumeErr && !redirect) |=> headValid >= $past(headValid)); // R8

endmodule

bind ibuf_word_queue ibuf_word_queue_chk #(
  .QBYTES(QBYTES), .BCNTW(BCNTW), .ADDRW(ADDRW)
) u_chk (
  .clk(clk), .rstN(rstN), .redirect(redirect), .fetchValid(fetchValid),
  .consumeErr(consumeErr), .consumeCnt(consumeCnt), .headValid(headValid),
  .fetchAddr(fetchAddr)
);

// File: tb/ibuf_word_queue_bench.sv
`timescale 1ns/1ps
module ibuf_word_queue_bench;
  localparam int QW = 8, WW = 16, TAGW = 4, AW = 32;
  localparam int QB = 2 * QW, WB = 2 * WW;

  logic clk = 1'b0, rstN = 1'b0;
  logic redirect = 1'b0, fetchValid = 1'b0, fetchSel = 1'b0;
  logic [AW-1:0] redirectAddr = '0;
  logic [3:0] wordOff = '0;
  logic [WB*8-1:0] icWin = '0, btWin = '0;
  logic [WB*TAGW-1:0] icTag = '0, btTag = '0;
  logic [AW-1:0] fetchAddr;
  logic [4:0] consumeCnt = '0;
  logic consumeErr;
  logic [4:0] headValid;
  logic [QB*8-1:0] headBytes;
  logic [QB*TAGW-1:0] headTags;

  int errors = 0, checks = 0;
  int mFirst = 0, mNf = 0;
  bit srcMap [int];
  bit finished = 0;

  always #2.5 clk = ~clk;

  ibuf_word_queue u_ibuf_word_queue (
    .clk(clk), .rstN(rstN), .redirect(redirect), .redirectAddr(redirectAddr),
    .fetchValid(fetchValid), .fetchSel(fetchSel), .wordOff(wordOff),
    .icWin(icWin), .icTag(icTag), .btWin(btWin), .btTag(btTag),
    .fetchAddr(fetchAddr), .consumeCnt(consumeCnt), .consumeErr(consumeErr),
    .headValid(headValid), .headBytes(headBytes), .headTags(headTags)
  );

  function automatic logic [7:0] memByte(int a, bit s);
    return 8'((a * 37 + 11) ^ (s ? 8'hA5 : 8'h00));
  endfunction

  function automatic logic [3:0] memTag(int a, bit s);
    return 4'((a * 3 + (a >> 4)) ^ (s ? 4'h9 : 4'h0));
  endfunction

  function automatic int mValid();
    return (mNf > mFirst) ? mNf - mFirst : 0;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    int v = mValid();
    int badIdx = -1;
    check(headValid == 5'(v), tag, "headValid", int'(headValid), v);
    check(fetchAddr == AW'(mNf), "R4", "fetchAddr", int'(fetchAddr), mNf);
    for (int i = 0; i < v; i++) begin
      bit s = srcMap.exists(mFirst + i) ? srcMap[mFirst + i] : 1'b0;
      if (headBytes[i*8 +: 8] != memByte(mFirst + i, s) ||
          headTags[i*TAGW +: TAGW] != memTag(mFirst + i, s)) begin
        if (badIdx < 0) badIdx = i;
      end
    end
    check(badIdx < 0, "R5", "head byte/tag mismatch index", badIdx, -1);
  endtask

  task automatic step(bit rd, int tgt, int cn, bit fv, bit sel, string tag);
    int v = mValid();
    int base = mNf & ~31;
    int words, freeW, availW, load;
    redirect = rd; redirectAddr = AW'(tgt); consumeCnt = 5'(cn);
    fetchValid = fv; fetchSel = sel; wordOff = 4'((mNf >> 1) % WW);
    for (int b = 0; b < WB; b++) begin
      icWin[b*8 +: 8] = memByte(base + b, 1'b0);
      btWin[b*8 +: 8] = memByte(base + b, 1'b1);
      icTag[b*TAGW +: TAGW] = memTag(base + b, 1'b0);
      btTag[b*TAGW +: TAGW] = memTag(base + b, 1'b1);
    end
    #1;
    check(consumeErr == (cn > v), "R8", "consumeErr", int'(consumeErr), int'(cn > v));
    if (rd) begin
      mFirst = tgt; mNf = tgt & ~1;
    end else begin
      words  = (mNf - (mFirst & ~1)) / 2;
      freeW  = QW - words;
      availW = WW - ((mNf >> 1) % WW);
      load   = fv ? ((availW < freeW) ? availW : freeW) : 0;
      for (int x = 0; x < 2 * load; x++) srcMap[mNf + x] = sel;
      if (cn <= v) mFirst += cn;
      mNf += 2 * load;
    end
    @(posedge clk); @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(headValid == 0, "R1", "headValid after reset", int'(headValid), 0);
    check(fetchAddr == 0, "R1", "fetchAddr after reset", int'(fetchAddr), 0);
    check(consumeErr == 0, "R1", "consumeErr after reset", int'(consumeErr), 0);
    @(negedge clk);

    // Whole queue filled in one clock from an aligned window.
    step(0, 0, 0, 1, 0, "R11");
    check(headValid == 16, "R11", "valid after one fetch", int'(headValid), 16);
    check(headBytes[7:0] == memByte(0, 0), "R2", "cache-path byte", int'(headBytes[7:0]), int'(memByte(0, 0)));

    // Partial consume: one word freed, odd byte stays at the head.
    step(0, 0, 3, 0, 0, "R6");
    check(headValid == 13, "R6", "valid after consuming 3", int'(headValid), 13);
    step(0, 0, 0, 1, 1, "R7");
    check(headValid == 15, "R7", "only one whole word refilled", int'(headValid), 15);
    check(headBytes[14*8 +: 8] == memByte(17, 1), "R2", "target-path byte", int'(headBytes[14*8 +: 8]), int'(memByte(17, 1)));

    // Over-large consume is ignored.
    step(0, 0, 16, 0, 0, "R8");
    check(headValid == 15, "R8", "valid after bad consume", int'(headValid), 15);

    // Redirect beats consume and fetch, odd target two words before window end.
    step(1, 29, 4, 1, 0, "R9");
    check(headValid == 0, "R9", "valid after redirect", int'(headValid), 0);
    check(fetchAddr == 28, "R9", "fetchAddr after redirect", int'(fetchAddr), 28);
    step(0, 0, 0, 1, 0, "R3");
    check(headValid == 3, "R10", "odd target hides first byte", int'(headValid), 3);
    check(headBytes[7:0] == memByte(29, 0), "R10", "head is target byte", int'(headBytes[7:0]), int'(memByte(29, 0)));
    check(fetchAddr == 32, "R3", "load stops at window end", int'(fetchAddr), 32);
    step(0, 0, 1, 1, 0, "R4");
    check(headValid == 14, "R4", "load limited by free slots", int'(headValid), 14);

    for (int n = 0; n < 3000; n++) begin
      int v = mValid();
      int cn;
      bit rd = ($urandom % 24) == 0;
      if (($urandom % 8) == 0 && v < QB) cn = v + 1 + int'($urandom % (QB - v));
      else cn = int'($urandom % (v + 1));
      step(rd, int'($urandom % 4096), cn, ($urandom % 4) != 0, 1'($urandom % 2), "R6");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule